// File: doc/BRIEF.md
# Instruction Fetch and Exception Entry Sequencer

This block sequences instruction fetch addresses for a processor that runs in one of two instruction states. In the wide state each instruction is 32 bits and the fetch pointer moves by 4 bytes. In the compact state each instruction is 16 bits and the pointer moves by 2 bytes. After every accepted fetch the block updates three values. The pointer for the next fetch advances. The address of the instruction now executing is recorded. The program counter value visible to software is set to two instructions beyond the executing instruction.

The block also performs entry into two exceptions, an interrupt request and a prefetch abort. On a taken entry the block does the following:
- It computes the vector address from a strap-selected base.
- It issues a fetch from that vector in wide state.
- It hands the register file the link value, the status word to save, a mode-switch request and the status-bit updates.

The interrupt-disable bit masks both exception kinds. A masked request is refused and the refusal is reported.

Fetches leave the block on a valid/ready channel: `fetch_valid`, `fetch_ready`, `fetch_addr` and `fetch_half`. While `fetch_valid` is high and `fetch_ready` is low, the address and size hold steady and the block accepts no new work. Both step requests and exception requests are ignored until the handshake completes. Any new request must be presented again after that point. Everything else is a plain control pin.

Top module: `fetch_exc_seq`

## Requirements
- R1: While reset is active and in the cycle after it is released, `fetch_valid` is 1, `fetch_addr` equals `reset_addr`, `fetch_half` is 0, and `visible_pc` and `inst_addr` are 0.
- R2: When a wide fetch (`fetch_half`=0) is accepted (`fetch_valid` and `fetch_ready` both high at a clock edge), then after that edge `inst_addr` equals the accepted address. `fetch_addr` equals the accepted address plus 4, `visible_pc` equals the new `fetch_addr` plus 4, and `fetch_valid` is 0.
- R3: When a compact fetch (`fetch_half`=1) is accepted, then after that edge `inst_addr` equals the accepted address. `fetch_addr` equals the accepted address plus 2, `visible_pc` equals the new `fetch_addr` plus 2, and `fetch_valid` is 0.
- R4: While `fetch_valid` is 1 and `fetch_ready` is 0, `fetch_addr` and `fetch_half` stay unchanged, `fetch_valid` stays 1, and `step` has no effect.
- R5: With no fetch outstanding and no exception taken, a `step` pulse makes `fetch_valid` 1 after the next edge. The fetch uses the unchanged `fetch_addr`, and `fetch_half` equals `state_compact` as sampled with the step.
- R6: The vector base is 0xFFFF0000 when `high_vec` is 1 and 0x00000000 when it is 0. An interrupt entry fetches from base+0x18 and an abort entry fetches from base+0x0C.
- R7: A request with `irq_mask`=1 and no fetch outstanding produces a one-cycle `entry_refused` pulse after the edge. It produces no `entry_taken`, and `fetch_addr` keeps its value.
- R8: A taken entry gives a one-cycle `entry_taken` pulse after the edge. In that cycle the strobe carries the following values:
  - `link_data` = `inst_addr` at the request plus 4.
  - `saved_status` = `status_in` at the request.
  - `mode_code` = 0x12 for an interrupt or 0x17 for an abort.
  - `new_compact` = 0 and `new_mask` = 1.
  - `wfi_clear` = 1.
- R9: In the cycle of `entry_taken`, `fetch_valid` is 1 with `fetch_half`=0 and `fetch_addr` equal to the vector.
- R10: When `irq_req` and `abort_req` are both high, the abort entry is taken.
- R11: While a fetch is outstanding, exception requests are ignored: neither `entry_taken` nor `entry_refused` follows, and `fetch_addr` is unchanged.
- R12: An exception taken in the same cycle as `step` wins. The fetch goes to the vector in wide state whatever the value of `state_compact`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_addr | input | 32 | Address of the first fetch after reset |
| high_vec | input | 1 | Strap: 1 selects the high vector base |
| state_compact | input | 1 | Current instruction-state bit (1 = 16-bit) |
| irq_mask | input | 1 | Current interrupt-disable bit |
| status_in | input | 32 | Current status word |
| irq_req | input | 1 | Interrupt request |
| abort_req | input | 1 | Prefetch-abort request |
| step | input | 1 | Executing instruction done; request the next fetch |
| fetch_ready | input | 1 | Memory accepts the fetch |
| fetch_valid | output | 1 | Fetch request valid |
| fetch_addr | output | 32 | Fetch address |
| fetch_half | output | 1 | Fetch size: 1 = halfword, 0 = word |
| inst_addr | output | 32 | Address of the instruction last fetched (executing) |
| visible_pc | output | 32 | Software-visible program counter |
| entry_taken | output | 1 | Exception entry strobe (link, saved status, status update) |
| entry_refused | output | 1 | Request refused because of the mask |
| mode_req | output | 1 | Mode-switch request to the register file |
| mode_code | output | 5 | Target mode: 0x12 interrupt, 0x17 abort |
| link_data | output | 32 | Value for the link register |
| saved_status | output | 32 | Status word to save in the new mode |
| new_compact | output | 1 | New instruction-state bit (valid with entry_taken) |
| new_mask | output | 1 | New interrupt-disable bit (valid with entry_taken) |
| wfi_clear | output | 1 | Clears any wait-for-interrupt condition |

## Verification
The bench sweeps both vector straps, both mask values and every combination of interrupt and abort requests. It checks the exact vector, link value, saved word and mode code of each outcome:
- A swapped priority shows up as the wrong vector.
- A wrong mask path shows up as either a taken entry or a missing refusal.

Runs of wide and compact fetches are interleaved with held-off ready, so that a wrong increment, a lagging visible PC, or an address that drifts under back-pressure changes the compared value. Requests raised while a fetch is outstanding, and steps with the compact bit set in the same cycle as an exception, expose a design that lets either kind of request slip through.

// File: rtl/fetch_exc_pkg.sv
package fetch_exc_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned MODE_W   = 5;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_IRQ  = 2'd1,
    EXC_ABT  = 2'd2
  } exc_kind_e;
endpackage

// File: rtl/fes_arbiter.sv
module fes_arbiter
  import fetch_exc_pkg::*;
(
  input  logic      busy,
  input  logic      irq_mask,
  input  logic      irq_req,
  input  logic      abort_req,
  input  logic      step,
  output exc_kind_e kind,
  output logic      refuse,
  output logic      issue_step
);
  logic any_req;

  always_comb begin
    any_req = irq_req | abort_req;
    kind    = EXC_NONE;
    if (!busy && !irq_mask) begin
      if (abort_req)    kind = EXC_ABT;
      else if (irq_req) kind = EXC_IRQ;
    end
    refuse     = !busy && irq_mask && any_req;
    issue_step = !busy && step && (kind == EXC_NONE);
  end
endmodule

// File: rtl/fes_pc_track.sv
module fes_pc_track #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reset_addr,
  input  logic          load_vec,
  input  logic [AW-1:0] vec_addr,
  input  logic          issue_step,
  input  logic          step_compact,
  input  logic          fetch_ready,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_half,
  output logic [AW-1:0] inst_addr,
  output logic [AW-1:0] visible_pc
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);
  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  logic [AW-1:0] next_q;
  logic [AW-1:0] inc;
  logic          accept;

  assign inc    = fetch_half ? HALF_STEP : WORD_STEP;
  assign accept = fetch_valid && fetch_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q      <= reset_addr;
      fetch_valid <= 1'b1;
      fetch_half  <= 1'b0;
      inst_addr   <= '0;
      visible_pc  <= '0;
    end else if (accept) begin
      inst_addr   <= next_q;
      next_q      <= next_q + inc;
      visible_pc  <= next_q + (inc << 1);
      fetch_valid <= 1'b0;
    end else if (load_vec) begin
      next_q      <= vec_addr;
      fetch_valid <= 1'b1;
      fetch_half  <= 1'b0;
    end else if (issue_step) begin
      fetch_valid <= 1'b1;
      fetch_half  <= step_compact;
    end
  end

  assign fetch_addr = next_q;

  // R4
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr) && $stable(fetch_half));

  // R2
  wide_pc_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !fetch_half |=> !fetch_valid && (visible_pc == fetch_addr + AW'(4))
                              && (fetch_addr == inst_addr + AW'(4)));

  // R3
  compact_pc_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fetch_half |=> !fetch_valid && (visible_pc == fetch_addr + AW'(2))
                             && (fetch_addr == inst_addr + AW'(2)));
endmodule

// File: rtl/fes_entry_out.sv
module fes_entry_out
  import fetch_exc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  exc_kind_e         kind,
  input  logic              refuse,
  input  logic [AW-1:0]     cur_inst,
  input  logic [SW-1:0]     status_in,
  output logic              entry_taken,
  output logic              entry_refused,
  output logic              mode_req,
  output logic [MODE_W-1:0] mode_code,
  output logic [AW-1:0]     link_data,
  output logic [SW-1:0]     saved_status,
  output logic              new_compact,
  output logic              new_mask,
  output logic              wfi_clear
);
  logic take;
  assign take = (kind != EXC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_taken   <= 1'b0;
      entry_refused <= 1'b0;
      mode_code     <= '0;
      link_data     <= '0;
      saved_status  <= '0;
    end else begin
      entry_taken   <= take;
      entry_refused <= refuse;
      if (take) begin
        mode_code    <= (kind == EXC_ABT) ? MODE_ABT : MODE_IRQ;
        link_data    <= cur_inst + AW'(4);
        saved_status <= status_in;
      end
    end
  end

  assign mode_req    = entry_taken;
  assign wfi_clear   = entry_taken;
  assign new_compact = 1'b0;
  assign new_mask    = entry_taken;

  // R7
  refuse_excludes_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_taken && entry_refused));
endmodule

// File: rtl/fetch_exc_seq.sv
module fetch_exc_seq
  import fetch_exc_pkg::*;
#(
  parameter int unsigned        AW        = ADDR_W,
  parameter int unsigned        SW        = STAT_W,
  parameter logic [ADDR_W-1:0]  HIGH_BASE = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0]  IRQ_OFS   = 32'h0000_0018,
  parameter logic [ADDR_W-1:0]  ABT_OFS   = 32'h0000_000C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reset_addr,
  input  logic              high_vec,
  input  logic              state_compact,
  input  logic              irq_mask,
  input  logic [SW-1:0]     status_in,
  input  logic              irq_req,
  input  logic              abort_req,
  input  logic              step,
  input  logic              fetch_ready,
  output logic              fetch_valid,
  output logic [AW-1:0]     fetch_addr,
  output logic              fetch_half,
  output logic [AW-1:0]     inst_addr,
  output logic [AW-1:0]     visible_pc,
  output logic              entry_taken,
  output logic              entry_refused,
  output logic              mode_req,
  output logic [MODE_W-1:0] mode_code,
  output logic [AW-1:0]     link_data,
  output logic [SW-1:0]     saved_status,
  output logic              new_compact,
  output logic              new_mask,
  output logic              wfi_clear
);
  localparam logic [AW-1:0] BASE_HI = AW'(HIGH_BASE);
  localparam logic [AW-1:0] OFS_IRQ = AW'(IRQ_OFS);
  localparam logic [AW-1:0] OFS_ABT = AW'(ABT_OFS);

  exc_kind_e     kind;
  logic          refuse;
  logic          issue_step;
  logic [AW-1:0] vec_base;
  logic [AW-1:0] vec_addr;

  fes_arbiter u_arb (
    .busy       (fetch_valid),
    .irq_mask   (irq_mask),
    .irq_req    (irq_req),
    .abort_req  (abort_req),
    .step       (step),
    .kind       (kind),
    .refuse     (refuse),
    .issue_step (issue_step)
  );

  always_comb begin
    vec_base = high_vec ? BASE_HI : '0;
    vec_addr = vec_base + ((kind == EXC_ABT) ? OFS_ABT : OFS_IRQ);
  end

  fes_pc_track #(.AW(AW)) u_pc (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_addr   (reset_addr),
    .load_vec     (kind != EXC_NONE),
    .vec_addr     (vec_addr),
    .issue_step   (issue_step),
    .step_compact (state_compact),
    .fetch_ready  (fetch_ready),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .fetch_half   (fetch_half),
    .inst_addr    (inst_addr),
    .visible_pc   (visible_pc)
  );

  fes_entry_out #(.AW(AW), .SW(SW)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .kind          (kind),
    .refuse        (refuse),
    .cur_inst      (inst_addr),
    .status_in     (status_in),
    .entry_taken   (entry_taken),
    .entry_refused (entry_refused),
    .mode_req      (mode_req),
    .mode_code     (mode_code),
    .link_data     (link_data),
    .saved_status  (saved_status),
    .new_compact   (new_compact),
    .new_mask      (new_mask),
    .wfi_clear     (wfi_clear)
  );

  // R9
  vector_fetch_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_taken |-> fetch_valid && !fetch_half
                    && (fetch_addr[3:0] == ((mode_code == MODE_ABT) ? 4'hC : 4'h8)));

  // R10
  abort_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_taken |-> ((mode_code == MODE_ABT) == $past(abort_req)));

  // R11
  busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> !entry_taken && !entry_refused);

  // R7
  masked_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid && irq_mask && (irq_req || abort_req) |=> entry_refused && !entry_taken);

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_taken |-> link_data == $past(inst_addr) + AW'(4));
endmodule

// File: tb/fetch_exc_seq_bench.sv
module fetch_exc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] reset_addr = '0;
  logic        high_vec = 1'b0, state_compact = 1'b0, irq_mask = 1'b0;
  logic [31:0] status_in = '0;
  logic        irq_req = 1'b0, abort_req = 1'b0, step = 1'b0, fetch_ready = 1'b0;
  logic        fetch_valid, fetch_half, entry_taken, entry_refused, mode_req;
  logic        new_compact, new_mask, wfi_clear;
  logic [31:0] fetch_addr, inst_addr, visible_pc, link_data, saved_status;
  logic [4:0]  mode_code;

  int checks = 0, fails = 0;
  logic [31:0] exp_next, exp_inst;

  always #5 clk = ~clk;

  fetch_exc_seq u_fetch_exc_seq (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] a);
    @(negedge clk);
    rst_n = 1'b0; reset_addr = a;
    @(negedge clk);
    chk(fetch_valid && fetch_addr == a && !fetch_half, "R1 in reset", fetch_addr, a);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_valid && fetch_addr == a && !fetch_half && visible_pc == 0 && inst_addr == 0,
        "R1 after reset", fetch_addr, a);
    exp_next = a; exp_inst = 0;
  endtask

  // accept the outstanding fetch after d cycles of back-pressure
  task automatic hand(input int d);
    logic h;
    logic [31:0] inc;
    h = fetch_half;
    inc = h ? 32'd2 : 32'd4;
    for (int i = 0; i < d; i++) begin
      step = 1'b1; state_compact = ~h; irq_req = 1'b1; irq_mask = i[0];
      @(negedge clk);
      chk(fetch_valid && fetch_addr == exp_next && fetch_half == h, "R4 hold", fetch_addr, exp_next);
      chk(!entry_taken && !entry_refused, "R11 busy ignore", {30'd0, entry_taken, entry_refused}, 0);
    end
    step = 1'b0; irq_req = 1'b0; irq_mask = 1'b0; fetch_ready = 1'b1;
    @(negedge clk);
    fetch_ready = 1'b0;
    exp_inst = exp_next; exp_next = exp_next + inc;
    chk(!fetch_valid && inst_addr == exp_inst && fetch_addr == exp_next,
        h ? "R3 advance" : "R2 advance", fetch_addr, exp_next);
    chk(visible_pc == exp_next + inc, h ? "R3 visible pc" : "R2 visible pc", visible_pc, exp_next + inc);
  endtask

  task automatic do_step(input logic c);
    step = 1'b1; state_compact = c;
    @(negedge clk);
    step = 1'b0;
    chk(fetch_valid && fetch_half == c && fetch_addr == exp_next, "R5 step issue", fetch_addr, exp_next);
  endtask

  task automatic exc(input logic hv, input logic m, input logic ir, input logic ab, input logic c);
    logic [31:0] st, vec, lnk;
    st = {hv, m, ir, ab, c, 3'b101, exp_next[23:0]};
    vec = (hv ? 32'hFFFF_0000 : 32'h0) + (ab ? 32'h0C : 32'h18);
    lnk = exp_inst + 32'd4;
    high_vec = hv; irq_mask = m; irq_req = ir; abort_req = ab; status_in = st;
    step = 1'b1; state_compact = c;
    @(negedge clk);
    irq_req = 1'b0; abort_req = 1'b0; step = 1'b0;
    if (m) begin
      chk(entry_refused && !entry_taken && !mode_req, "R7 refused", {31'd0, entry_refused}, 1);
      chk(fetch_valid && fetch_addr == exp_next && fetch_half == c, "R7 no vector", fetch_addr, exp_next);
    end else begin
      chk(entry_taken && !entry_refused && mode_req, "R8 taken", {31'd0, entry_taken}, 1);
      chk(fetch_valid && !fetch_half && fetch_addr == vec, ab ? "R10 R6 R12 abort vector" : "R6 R12 R9 irq vector",
          fetch_addr, vec);
      chk(link_data == lnk, "R8 link", link_data, lnk);
      chk(saved_status == st, "R8 saved status", saved_status, st);
      chk(mode_code == (ab ? 5'h17 : 5'h12), "R8 R10 mode", {27'd0, mode_code}, ab ? 32'h17 : 32'h12);
      chk(!new_compact && new_mask && wfi_clear, "R8 status update", {29'd0, new_compact, new_mask, wfi_clear}, 3);
      exp_next = vec;
    end
    @(negedge clk);
    chk(!entry_taken && !entry_refused, "R8 pulse one cycle", {30'd0, entry_taken, entry_refused}, 0);
    irq_mask = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) begin
      do_reset(r == 3 ? 32'hFFFF_FFF0 : 32'h0100_0000 * r + 32'h40 * r);
      hand(r);
      for (int k = 0; k < 12; k++) begin
        do_step(k[1] ^ k[0] ^ r[0]);
        hand(k % 3);
      end
    end
    do_reset(32'h0000_2000);
    hand(0);
    for (int hv = 0; hv < 2; hv++)
      for (int m = 0; m < 2; m++)
        for (int q = 1; q < 4; q++)
          for (int c = 0; c < 2; c++) begin
            exc(hv[0], m[0], q[0], q[1], c[0]);
            hand(c);
            do_step(1'b1);
            hand(0);
          end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule